// File: doc/BRIEF.md
# ADC Result Status and Interrupt Controller

This block sits between a two-channel converter subsystem and a CPU register bus. Channel one carries current results. Channel two carries either voltage or temperature results, picked per conversion by a select line. Each accepted result is stored in a channel data register. A 16-bit status word tracks four kinds of flags: result ready, out-of-range error, current-threshold crossing and calibration complete. The low byte of that word, gated by a mask register, drives one interrupt line.

Reads of the data registers clear the ready flags in a fixed cross-channel pattern. A ready flag that is still set makes its data register refuse new results, so software always reads a matching pair. The exception is when the core is powered down: then the newest result always wins. An out-of-range conversion is stored clamped to full scale. Its error flag stays set until an in-range result is stored on that channel.

Register reads and writes are single-cycle strobes on a small address space. Read data appears on the cycle after the read strobe. Any clearing caused by a read happens on the same edge that captures the read data.

Top module: `adc_stat_irq`

## Requirements
- R1: `irq` is high exactly when some status bit in 7..0 is set together with the matching mask bit. Status bits 15..8 never raise `irq`.
- R2: The mask register (address 3) holds eight enables. Mask bit i gates only status bit i, and a mask of zero for a set bit keeps `irq` low.
- R3: A read of the current data register (address 1) clears status bits 0, 1, 2 and 5. A read of the voltage/temperature data register (address 2) clears bits 1 and 2. It also clears bit 0 when the current channel is disabled (`i_en` low). It leaves bit 0 set otherwise.
- R4: A result is not stored while its channel's ready flag is set. The current channel is held by bit 0, and the voltage/temperature channel by bit 1 or bit 2.
- R5: While `core_pd` is high, every conversion on an enabled channel is stored regardless of its ready flag.
- R6: A stored result sets its ready flag: bit 0 for current, bit 1 for voltage (`vt_sel`=0), bit 2 for temperature (`vt_sel`=1). A conversion on a disabled channel is neither stored nor flagged.
- R7: An overrange conversion is stored as 0x7FFF and an underrange one as 0x8000, with overrange taking precedence. Either sets the channel's error flag: bit 12 for current, bit 13 for voltage/temperature. The error flag clears when an in-range result is stored on that channel.
- R8: When the comparator is on (bit 0 of address 7), storing a current result whose two's-complement magnitude exceeds the threshold (address 4) sets status bit 4. A magnitude equal to the threshold does not set it. Bit 4 clears on any write to address 5, 6 or 7.
- R9: When continuous mode is on (bit 0 of address 5), every current conversion strobe sets status bit 5, even one that is held off. Bit 5 clears on a current data read.
- R10: A `cal_done` pulse sets bit 15 and the ready bits of all enabled channels. Bit 15 clears on a write to address 5, 6 or 7.
- R11: The status register (address 0) resets to 0x0000 and ignores writes. Bits 14, 11..6 and 3 always read as zero.
- R12: If a clearing data read and a new result on the same channel arrive in the same cycle, the read returns the old value, the clear happens first, and the new result is stored and flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | BW | Write data |
| bus_rdata | output | BW | Read data, valid the cycle after `bus_rd` |
| i_vld | input | 1 | Current conversion strobe |
| i_data | input | DW | Current conversion result |
| i_ovr | input | 1 | Current result overrange |
| i_und | input | 1 | Current result underrange |
| vt_vld | input | 1 | Voltage/temperature conversion strobe |
| vt_sel | input | 1 | 0 = voltage, 1 = temperature |
| vt_data | input | DW | Voltage/temperature result |
| vt_ovr | input | 1 | Voltage/temperature overrange |
| vt_und | input | 1 | Voltage/temperature underrange |
| cal_done | input | 1 | Calibration complete pulse |
| i_en | input | 1 | Current channel enable |
| v_en | input | 1 | Voltage channel enable |
| t_en | input | 1 | Temperature channel enable |
| core_pd | input | 1 | Core powered down, disables hold-off |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its defaults: a 16-bit bus and 16-bit results. At that width the clamp codes 0x7FFF and 0x8000 can be compared directly against hand-written expected values. The magnitude of 0x8000 is used to check that the threshold test does not overflow. The threshold is set to 0x0100, so that -256 sits exactly on the boundary and -257 sits just past it.

// File: rtl/adcsi_pkg.sv
package adcsi_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned SW = 16;
  localparam int unsigned MW = 8;

  typedef enum logic [AW-1:0] {
    A_STAT = 3'd0,
    A_CDAT = 3'd1,
    A_VDAT = 3'd2,
    A_MASK = 3'd3,
    A_THR  = 3'd4,
    A_MODE = 3'd5,
    A_FILT = 3'd6,
    A_CCFG = 3'd7
  } reg_addr_e;

  localparam int unsigned B_RDY_I = 0;
  localparam int unsigned B_RDY_V = 1;
  localparam int unsigned B_RDY_T = 2;
  localparam int unsigned B_THR   = 4;
  localparam int unsigned B_CONT  = 5;
  localparam int unsigned B_ERR_I = 12;
  localparam int unsigned B_ERR_V = 13;
  localparam int unsigned B_CAL   = 15;

  localparam int unsigned NCH = 2;
  localparam int unsigned CH_I = 0;
  localparam int unsigned CH_V = 1;
endpackage

// File: rtl/adcsi_chan.sv
module adcsi_chan #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          en,
  input  logic          hold,
  input  logic          bypass,
  input  logic          ovr,
  input  logic          und,
  input  logic [DW-1:0] din,
  output logic          acc,
  output logic [DW-1:0] val,
  output logic [DW-1:0] data_q,
  output logic          err_q
);
  localparam logic [DW-1:0] PFS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NFS = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] data_d;
  logic          err_d;

  always_comb begin
    if (ovr)      val = PFS;
    else if (und) val = NFS;
    else          val = din;
    acc    = vld & en & (~hold | bypass);
    data_d = data_q;
    err_d  = err_q;
    if (acc) begin
      data_d = val;
      err_d  = ovr | und;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (acc) begin
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  // R4
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !bypass) |=> $stable(data_q));

  // R7
  clamp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && en && ovr && (!hold || bypass)) |=> (data_q == PFS && err_q));

  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && en && !ovr && !und && (!hold || bypass)) |=> !err_q);

  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && en && bypass && !ovr && !und) |=> data_q == $past(din));
endmodule

// File: rtl/adcsi_flags.sv
module adcsi_flags
  import adcsi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic          acc_vt,
  input  logic          vt_sel,
  input  logic          vld_i,
  input  logic          i_en,
  input  logic          v_en,
  input  logic          t_en,
  input  logic          cal_done,
  input  logic          rd_cur,
  input  logic          rd_vt,
  input  logic          reconf,
  input  logic          cont_en,
  input  logic          cmp_en,
  input  logic          cmp_hit,
  input  logic          err_i,
  input  logic          err_vt,
  output logic          hold_i,
  output logic          hold_vt,
  output logic [SW-1:0] status
);
  logic rdy_i_q, rdy_v_q, rdy_t_q, thr_q, cont_q, cal_q;
  logic rdy_i_d, rdy_v_d, rdy_t_d, thr_d, cont_d, cal_d;
  logic clr_i, clr_vt;

  always_comb begin
    clr_i   = rd_cur | (rd_vt & ~i_en);
    clr_vt  = rd_cur | rd_vt;
    hold_i  = rdy_i_q & ~clr_i;
    hold_vt = (rdy_v_q | rdy_t_q) & ~clr_vt;
    rdy_i_d = hold_i | acc_i | (cal_done & i_en);
    rdy_v_d = (rdy_v_q & ~clr_vt) | (acc_vt & ~vt_sel) | (cal_done & v_en);
    rdy_t_d = (rdy_t_q & ~clr_vt) | (acc_vt & vt_sel) | (cal_done & t_en);
    cont_d  = (cont_q & ~rd_cur) | (vld_i & cont_en);
    thr_d   = (thr_q & ~reconf) | (acc_i & cmp_en & cmp_hit);
    cal_d   = (cal_q & ~reconf) | cal_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_i_q <= 1'b0;
      rdy_v_q <= 1'b0;
      rdy_t_q <= 1'b0;
      thr_q   <= 1'b0;
      cont_q  <= 1'b0;
      cal_q   <= 1'b0;
    end else begin
      rdy_i_q <= rdy_i_d;
      rdy_v_q <= rdy_v_d;
      rdy_t_q <= rdy_t_d;
      thr_q   <= thr_d;
      cont_q  <= cont_d;
      cal_q   <= cal_d;
    end
  end

  always_comb begin
    status          = '0;
    status[B_RDY_I] = rdy_i_q;
    status[B_RDY_V] = rdy_v_q;
    status[B_RDY_T] = rdy_t_q;
    status[B_THR]   = thr_q;
    status[B_CONT]  = cont_q;
    status[B_ERR_I] = err_i;
    status[B_ERR_V] = err_vt;
    status[B_CAL]   = cal_q;
  end

  // R3
  cur_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cur && !acc_i && !acc_vt && !cal_done) |=> (status[2:0] == 3'b000));

  // R9
  cont_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cur && !vld_i) |=> !status[B_CONT]);

  // R10
  cal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> status[B_CAL]);
endmodule

// File: rtl/adcsi_regs.sv
module adcsi_regs
  import adcsi_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic [SW-1:0] status,
  input  logic [DW-1:0] cur_data,
  input  logic [DW-1:0] vt_data,
  output logic [BW-1:0] rdata,
  output logic          rd_cur,
  output logic          rd_vt,
  output logic          reconf,
  output logic          cont_en,
  output logic          cmp_en,
  output logic [DW-1:0] thresh,
  output logic [MW-1:0] mask
);
  logic [BW-1:0] filt_q, rmux;
  logic [MW-1:0] mask_d;
  logic [DW-1:0] thr_d;
  logic [BW-1:0] filt_d;
  logic          cont_d, cmp_d;
  logic          we_mask, we_thr, we_mode, we_filt, we_ccfg;

  always_comb begin
    rd_cur  = rd_en & (addr == A_CDAT);
    rd_vt   = rd_en & (addr == A_VDAT);
    we_mask = wr_en & (addr == A_MASK);
    we_thr  = wr_en & (addr == A_THR);
    we_mode = wr_en & (addr == A_MODE);
    we_filt = wr_en & (addr == A_FILT);
    we_ccfg = wr_en & (addr == A_CCFG);
    reconf  = we_mode | we_filt | we_ccfg;
    mask_d  = we_mask ? wdata[MW-1:0] : mask;
    thr_d   = we_thr  ? DW'(wdata)    : thresh;
    cont_d  = we_mode ? wdata[0]      : cont_en;
    filt_d  = we_filt ? wdata         : filt_q;
    cmp_d   = we_ccfg ? wdata[0]      : cmp_en;
    case (addr)
      A_STAT:  rmux = BW'(status);
      A_CDAT:  rmux = BW'($signed(cur_data));
      A_VDAT:  rmux = BW'($signed(vt_data));
      A_MASK:  rmux = BW'(mask);
      A_THR:   rmux = BW'(thresh);
      A_MODE:  rmux = BW'(cont_en);
      A_FILT:  rmux = filt_q;
      default: rmux = BW'(cmp_en);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      thresh  <= '0;
      cont_en <= 1'b0;
      filt_q  <= '0;
      cmp_en  <= 1'b0;
      rdata   <= '0;
    end else begin
      mask    <= mask_d;
      thresh  <= thr_d;
      cont_en <= cont_d;
      filt_q  <= filt_d;
      cmp_en  <= cmp_d;
      if (rd_en) rdata <= rmux;
    end
  end
endmodule

// File: rtl/adc_stat_irq.sv
module adc_stat_irq
  import adcsi_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          i_vld,
  input  logic [DW-1:0] i_data,
  input  logic          i_ovr,
  input  logic          i_und,
  input  logic          vt_vld,
  input  logic          vt_sel,
  input  logic [DW-1:0] vt_data,
  input  logic          vt_ovr,
  input  logic          vt_und,
  input  logic          cal_done,
  input  logic          i_en,
  input  logic          v_en,
  input  logic          t_en,
  input  logic          core_pd,
  output logic          irq
);
  logic          rs_q1, rs_q2, rst_s;
  logic [SW-1:0] status;
  logic [MW-1:0] mask;
  logic [DW-1:0] thresh;
  logic          rd_cur, rd_vt, reconf, cont_en, cmp_en, cmp_hit;
  logic          hold_i, hold_vt;

  logic          c_vld  [NCH];
  logic          c_en   [NCH];
  logic          c_hold [NCH];
  logic          c_ovr  [NCH];
  logic          c_und  [NCH];
  logic [DW-1:0] c_din  [NCH];
  logic          c_acc  [NCH];
  logic [DW-1:0] c_val  [NCH];
  logic [DW-1:0] c_data [NCH];
  logic          c_err  [NCH];
  logic [DW:0]   i_ext, i_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_s = rs_q2;

  always_comb begin
    c_vld[CH_I]  = i_vld;
    c_en[CH_I]   = i_en;
    c_hold[CH_I] = hold_i;
    c_ovr[CH_I]  = i_ovr;
    c_und[CH_I]  = i_und;
    c_din[CH_I]  = i_data;
    c_vld[CH_V]  = vt_vld;
    c_en[CH_V]   = vt_sel ? t_en : v_en;
    c_hold[CH_V] = hold_vt;
    c_ovr[CH_V]  = vt_ovr;
    c_und[CH_V]  = vt_und;
    c_din[CH_V]  = vt_data;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    adcsi_chan #(.DW(DW)) u_ch (
      .clk   (clk),
      .rst_n (rst_s),
      .vld   (c_vld[g]),
      .en    (c_en[g]),
      .hold  (c_hold[g]),
      .bypass(core_pd),
      .ovr   (c_ovr[g]),
      .und   (c_und[g]),
      .din   (c_din[g]),
      .acc   (c_acc[g]),
      .val   (c_val[g]),
      .data_q(c_data[g]),
      .err_q (c_err[g])
    );
  end

  always_comb begin
    i_ext   = {c_val[CH_I][DW-1], c_val[CH_I]};
    i_mag   = i_ext[DW] ? (~i_ext + 1'b1) : i_ext;
    cmp_hit = i_mag > {1'b0, thresh};
  end

  adcsi_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_s),
    .acc_i   (c_acc[CH_I]),
    .acc_vt  (c_acc[CH_V]),
    .vt_sel  (vt_sel),
    .vld_i   (i_vld),
    .i_en    (i_en),
    .v_en    (v_en),
    .t_en    (t_en),
    .cal_done(cal_done),
    .rd_cur  (rd_cur),
    .rd_vt   (rd_vt),
    .reconf  (reconf),
    .cont_en (cont_en),
    .cmp_en  (cmp_en),
    .cmp_hit (cmp_hit),
    .err_i   (c_err[CH_I]),
    .err_vt  (c_err[CH_V]),
    .hold_i  (hold_i),
    .hold_vt (hold_vt),
    .status  (status)
  );

  adcsi_regs #(.DW(DW), .BW(BW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s),
    .rd_en   (bus_rd),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .status  (status),
    .cur_data(c_data[CH_I]),
    .vt_data (c_data[CH_V]),
    .rdata   (bus_rdata),
    .rd_cur  (rd_cur),
    .rd_vt   (rd_vt),
    .reconf  (reconf),
    .cont_en (cont_en),
    .cmp_en  (cmp_en),
    .thresh  (thresh),
    .mask    (mask)
  );

  assign irq = |(status[MW-1:0] & mask);

  // R1
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_s)
    irq |-> (|status[MW-1:0]));

  // R8
  thr_clr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (reconf && !c_acc[CH_I]) |=> !status[B_THR]);
endmodule

// File: tb/tb_adc_stat_irq.sv
module tb_adc_stat_irq;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 16;
  localparam int unsigned BW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_rd, bus_wr;
  logic [2:0]    bus_addr;
  logic [BW-1:0] bus_wdata, bus_rdata;
  logic          i_vld, i_ovr, i_und, vt_vld, vt_sel, vt_ovr, vt_und;
  logic [DW-1:0] i_data, vt_data;
  logic          cal_done, i_en, v_en, t_en, core_pd, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic rd_q = 1'b0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_stat_irq #(.DW(DW), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .i_vld(i_vld), .i_data(i_data), .i_ovr(i_ovr), .i_und(i_und),
    .vt_vld(vt_vld), .vt_sel(vt_sel), .vt_data(vt_data), .vt_ovr(vt_ovr),
    .vt_und(vt_und), .cal_done(cal_done), .i_en(i_en), .v_en(v_en),
    .t_en(t_en), .core_pd(core_pd), .irq(irq)
  );

  always @(posedge clk) rd_q <= bus_rd;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic ci(input logic [15:0] d, input logic o, input logic u);
    i_vld = 1'b1; i_data = d; i_ovr = o; i_und = u;
    tick();
    i_vld = 1'b0; i_ovr = 1'b0; i_und = 1'b0;
  endtask

  task automatic cv(input logic s, input logic [15:0] d, input logic o, input logic u);
    vt_vld = 1'b1; vt_sel = s; vt_data = d; vt_ovr = o; vt_und = u;
    tick();
    vt_vld = 1'b0; vt_ovr = 1'b0; vt_und = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    i_vld = 0; i_data = 0; i_ovr = 0; i_und = 0;
    vt_vld = 0; vt_sel = 0; vt_data = 0; vt_ovr = 0; vt_und = 0;
    cal_done = 0; i_en = 1; v_en = 1; t_en = 1; core_pd = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R11 reset value
    rd(3'd0, 16'h0000, "R11 reset status");
    chk_irq(1'b0, "R1 reset irq");

    wr(3'd3, 16'h00FF);
    ci(16'h1234, 0, 0);
    chk_irq(1'b1, "R1 ready raises irq");
    rd(3'd0, 16'h0001, "R6 current ready");
    ci(16'h5555, 0, 0);
    rd(3'd1, 16'h1234, "R4 held result");
    rd(3'd0, 16'h0000, "R3 current read clears");
    ci(16'h5555, 0, 0);
    rd(3'd1, 16'h5555, "R4 accepted after clear");

    cv(1'b0, 16'h0100, 0, 0);
    rd(3'd0, 16'h0002, "R6 voltage ready");
    rd(3'd2, 16'h0100, "R3 vt data");
    rd(3'd0, 16'h0000, "R3 vt read clears");
    ci(16'h0001, 0, 0);
    cv(1'b1, 16'h0002, 0, 0);
    rd(3'd0, 16'h0005, "R6 temperature ready");
    rd(3'd2, 16'h0002, "R6 temperature data");
    rd(3'd0, 16'h0001, "R3 vt read keeps bit0");
    cv(1'b0, 16'h0003, 0, 0);
    rd(3'd1, 16'h0001, "R3 cur data");
    rd(3'd0, 16'h0000, "R3 cur read clears all");
    rd(3'd2, 16'h0003, "R6 vt data");

    ci(16'h0010, 1, 0);
    rd(3'd0, 16'h1001, "R7 current error");
    rd(3'd1, 16'h7FFF, "R7 clamp positive");
    chk_irq(1'b0, "R1 high bits no irq");
    ci(16'h0000, 0, 1);
    rd(3'd1, 16'h8000, "R7 clamp negative");
    ci(16'h0022, 0, 0);
    rd(3'd0, 16'h0001, "R7 error clears");
    rd(3'd1, 16'h0022, "R7 in-range data");
    cv(1'b0, 16'h0044, 1, 0);
    rd(3'd0, 16'h2002, "R7 vt error");
    rd(3'd2, 16'h7FFF, "R7 vt clamp");
    cv(1'b0, 16'h0005, 0, 0);
    rd(3'd0, 16'h0002, "R7 vt error clears");
    rd(3'd2, 16'h0005, "R7 vt data");

    wr(3'd3, 16'h0002);
    ci(16'h0007, 0, 0);
    chk_irq(1'b0, "R2 masked bit0");
    cv(1'b0, 16'h0009, 0, 0);
    chk_irq(1'b1, "R2 unmasked bit1");
    rd(3'd1, 16'h0007, "R2 cur data");
    wr(3'd3, 16'h00FF);

    wr(3'd4, 16'h0100);
    wr(3'd7, 16'h0001);
    ci(16'hFF00, 0, 0);
    rd(3'd0, 16'h0001, "R8 equal magnitude no trip");
    rd(3'd1, 16'hFF00, "R8 data");
    ci(16'hFEFF, 0, 0);
    rd(3'd1, 16'hFEFF, "R8 data");
    rd(3'd0, 16'h0010, "R8 threshold trip");
    chk_irq(1'b1, "R8 threshold irq");
    wr(3'd6, 16'h0000);
    rd(3'd0, 16'h0000, "R8 reconfigure clears");
    ci(16'h0000, 0, 1);
    rd(3'd1, 16'h8000, "R8 full-scale data");
    rd(3'd0, 16'h1010, "R8 full-scale magnitude trips");
    wr(3'd7, 16'h0000);
    ci(16'h7000, 0, 0);
    rd(3'd0, 16'h0001, "R8 comparator off");
    rd(3'd1, 16'h7000, "R8 data");

    wr(3'd5, 16'h0001);
    ci(16'h0003, 0, 0);
    rd(3'd0, 16'h0021, "R9 continuous bit");
    rd(3'd1, 16'h0003, "R9 data");
    ci(16'h0004, 0, 0);
    ci(16'h0005, 0, 0);
    rd(3'd1, 16'h0004, "R9 held conversion");
    rd(3'd0, 16'h0000, "R9 cleared by read");
    wr(3'd5, 16'h0000);

    cal_done = 1'b1; tick(); cal_done = 1'b0;
    rd(3'd0, 16'h8007, "R10 calibration");
    rd(3'd2, 16'h0009, "R10 vt data");
    rd(3'd0, 16'h8001, "R10 after vt read");
    rd(3'd1, 16'h0004, "R10 cur data");
    rd(3'd0, 16'h8000, "R10 bit15 persists");
    wr(3'd5, 16'h0000);
    rd(3'd0, 16'h0000, "R10 bit15 cleared");

    core_pd = 1'b1;
    ci(16'h000A, 0, 0);
    ci(16'h000B, 0, 0);
    rd(3'd1, 16'h000B, "R5 newest result");
    core_pd = 1'b0;

    ci(16'h000D, 0, 0);
    i_en = 1'b0;
    rd(3'd2, 16'h0009, "R3 vt data");
    rd(3'd0, 16'h0000, "R3 disabled current cleared by vt read");
    ci(16'h000E, 0, 0);
    rd(3'd0, 16'h0000, "R6 disabled no flag");
    rd(3'd1, 16'h000D, "R6 disabled no store");
    i_en = 1'b1;

    ci(16'h000E, 0, 0);
    bus_rd = 1'b1; bus_addr = 3'd1;
    exp_q.push_back(16'h000E); tag_q.push_back("R12 read returns old");
    i_vld = 1'b1; i_data = 16'h000F;
    tick();
    bus_rd = 1'b0; i_vld = 1'b0;
    rd(3'd0, 16'h0001, "R12 new result flagged");
    rd(3'd1, 16'h000F, "R12 new result stored");

    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h0000, "R11 status ignores writes");
    chk_irq(1'b0, "R1 idle irq");

    repeat (3) tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule